// File: doc/BRIEF.md
# Per-Domain External Interrupt Router

This block sits beside one hart and gathers the external interrupt lines raised by the per-domain interrupt controllers, one controller per supervisor domain. It qualifies each pending line with its enable bit. It drops the controller that belongs to the domain now running, selected by index, because that controller reaches the hart through the ordinary supervisor external interrupt. It then reports whether any other domain has work waiting.

Each qualified source is steered by its own delegation bit. A source is sent either to the running supervisor domain as a maskable notification, or to machine level as a trap request. Firmware only changes the active index on a domain switch and does not rewrite the enable mask. Machine software can also inject a notification directly. All outputs are registered.

Top module: `dom_xirq_route`

## Requirements
- R1: Every output changes only on the rising clock edge after its inputs change, so there is one cycle of latency. While rst_ni is low, all outputs are 0.
- R2: sum_pend_o is the OR of (pend_i AND en_i) over all bit positions, except the bit whose position equals act_idx_i, which never contributes.
- R3: When act_idx_i is N or greater, no bit is excluded and every qualified source contributes to sum_pend_o.
- R4: A qualified source whose bit in deleg_i is 0 raises m_req_o when m_en_i is 1.
- R5: A qualified source whose deleg_i bit is 1 sets s_pend_o when s_deleg_i is 1. It raises s_req_o only when s_en_i and m_en_i are both 1. Otherwise s_pend_o stays 1 and s_req_o stays 0.
- R6: When s_deleg_i is 0, a qualified source with its deleg_i bit set is routed to the machine path: s_pend_o stays 0 and m_req_o is 1 if m_en_i is 1.
- R7: When m_en_i is 0, m_req_o and s_req_o are 0, while sum_pend_o and s_pend_o still show the pending state.
- R8: When a machine-path source and a supervisor notification are both present, m_req_o is 1 and s_req_o is 0, and s_pend_o remains 1.
- R9: inj_i set to 1 makes s_pend_o 1 with no qualified source and with s_deleg_i at 0. The injected bit then gives s_req_o under the same s_en_i and m_en_i conditions as R5. It does not affect sum_pend_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | N | Pending line from each domain controller |
| en_i | input | N | Per-controller enable |
| deleg_i | input | N | Per-controller delegation to supervisor (1) or machine (0) |
| act_idx_i | input | $clog2(N)+1 | Index of the active domain's controller |
| m_en_i | input | 1 | Machine-level enable of the summary interrupt |
| s_deleg_i | input | 1 | Global delegation of the summary interrupt to supervisor |
| s_en_i | input | 1 | Supervisor enable of the notification |
| inj_i | input | 1 | Machine software's injected notification bit |
| sum_pend_o | output | 1 | Any other domain has a qualified interrupt |
| s_pend_o | output | 1 | Supervisor-visible notification pending |
| m_req_o | output | 1 | Machine-level trap request |
| s_req_o | output | 1 | Supervisor-level trap request |

## Verification
A machine-path source and a supervisor notification can be present in the same cycle. The bench provokes this by enabling two sources at once, one delegated and one not, and also by pairing an injected notification with a non-delegated source. It judges the cycle by requiring m_req_o high, s_req_o low and s_pend_o still high. Randomized vectors over all control combinations, checked against a model in the bench, cover the remaining overlaps.

// File: rtl/dxr_pkg.sv
package dxr_pkg;
  typedef struct packed {
    logic sum_pend;
    logic s_pend;
    logic m_req;
    logic s_req;
  } dxr_out_t;
endpackage

// File: rtl/dxr_qualify.sv
module dxr_qualify #(
  parameter int N  = 32,
  parameter int IW = $clog2(N) + 1
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  input  logic [IW-1:0] act_idx_i,
  output logic [N-1:0]  qual_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    // the active controller is served by the ordinary external interrupt
    assign qual_o[g] = pend_i[g] & en_i[g] & (act_idx_i != IW'(g));
  end
endmodule

// File: rtl/dxr_split.sv
module dxr_split #(
  parameter int N = 32
) (
  input  logic [N-1:0] qual_i,
  input  logic [N-1:0] deleg_i,
  input  logic         s_deleg_i,
  output logic         fwd_any_o,
  output logic         mach_any_o
);
  logic [N-1:0] fwd;
  assign fwd        = qual_i & deleg_i & {N{s_deleg_i}};
  assign fwd_any_o  = |fwd;
  assign mach_any_o = |(qual_i & ~fwd);
endmodule

// File: rtl/dxr_arb.sv
module dxr_arb
  import dxr_pkg::*;
(
  input  logic     sum_i,
  input  logic     fwd_any_i,
  input  logic     mach_any_i,
  input  logic     inj_i,
  input  logic     m_en_i,
  input  logic     s_en_i,
  output dxr_out_t out_o
);
  always_comb begin
    out_o.sum_pend = sum_i;
    out_o.s_pend   = fwd_any_i | inj_i;
    out_o.m_req    = m_en_i & mach_any_i;
    // machine path wins over the notification
    out_o.s_req    = m_en_i & s_en_i & out_o.s_pend & ~mach_any_i;
  end
endmodule

// File: rtl/dom_xirq_route.sv
module dom_xirq_route
  import dxr_pkg::*;
#(
  parameter int N  = 32,
  parameter int IW = $clog2(N) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  en_i,
  input  logic [N-1:0]  deleg_i,
  input  logic [IW-1:0] act_idx_i,
  input  logic          m_en_i,
  input  logic          s_deleg_i,
  input  logic          s_en_i,
  input  logic          inj_i,
  output logic          sum_pend_o,
  output logic          s_pend_o,
  output logic          m_req_o,
  output logic          s_req_o
);
  logic [N-1:0] qual;
  logic         fwd_any, mach_any;
  dxr_out_t     nxt, q;

  dxr_qualify #(.N(N), .IW(IW)) u_qual (
    .pend_i(pend_i), .en_i(en_i), .act_idx_i(act_idx_i), .qual_o(qual)
  );

  dxr_split #(.N(N)) u_split (
    .qual_i(qual), .deleg_i(deleg_i), .s_deleg_i(s_deleg_i),
    .fwd_any_o(fwd_any), .mach_any_o(mach_any)
  );

  dxr_arb u_arb (
    .sum_i(|qual), .fwd_any_i(fwd_any), .mach_any_i(mach_any),
    .inj_i(inj_i), .m_en_i(m_en_i), .s_en_i(s_en_i), .out_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign sum_pend_o = q.sum_pend;
  assign s_pend_o   = q.s_pend;
  assign m_req_o    = q.m_req;
  assign s_req_o    = q.s_req;

  p_active_excluded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_idx_i < IW'(N) && (pend_i & en_i) == (N'(1) << act_idx_i)) |=> !sum_pend_o);
  p_sreq_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_req_o |-> (s_pend_o && $past(s_en_i)));
  p_req_needs_men_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o || s_req_o) |-> $past(m_en_i));
  p_mreq_priority_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> !s_req_o);
  p_inject_pends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_i |=> s_pend_o);
endmodule

// File: tb/dom_xirq_route_bench.sv
module dom_xirq_route_bench;
  localparam int N = 32;
  localparam int IW = $clog2(N) + 1;
  localparam time T_CLK = 10ns;

  logic clk = 0, rst_ni = 0;
  logic [N-1:0] pend, en, deleg;
  logic [IW-1:0] act;
  logic m_en, s_deleg, s_en, inj;
  logic sum_pend, s_pend, m_req, s_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(T_CLK/2) clk = ~clk;

  dom_xirq_route #(.N(N)) u_dom_xirq_route (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .act_idx_i(act), .m_en_i(m_en), .s_deleg_i(s_deleg), .s_en_i(s_en), .inj_i(inj),
    .sum_pend_o(sum_pend), .s_pend_o(s_pend), .m_req_o(m_req), .s_req_o(s_req)
  );

  task automatic chk(string tag, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic apply(string tag, logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] d,
                       logic [IW-1:0] a, logic me, logic sd, logic se, logic ij);
    logic [N-1:0] q, f;
    logic e_sum, e_sp, e_mh, e_mr, e_sr;
    pend = p; en = e; deleg = d; act = a; m_en = me; s_deleg = sd; s_en = se; inj = ij;
    q = p & e;
    if (int'(a) < N) q[a] = 1'b0;
    f = q & d & {N{sd}};
    e_sum = |q;
    e_mh = |(q & ~f);
    e_sp = (|f) | ij;
    e_mr = me & e_mh;
    e_sr = me & se & e_sp & ~e_mh;
    @(negedge clk);
    chk({tag, " sum_pend"}, sum_pend, e_sum);
    chk({tag, " s_pend"}, s_pend, e_sp);
    chk({tag, " m_req"}, m_req, e_mr);
    chk({tag, " s_req"}, s_req, e_sr);
  endtask

  task automatic t_reset();
    pend = '1; en = '1; deleg = '0; act = '1; m_en = 1; s_deleg = 1; s_en = 1; inj = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset sum", sum_pend, 0); chk("R1 reset sp", s_pend, 0);
    chk("R1 reset mr", m_req, 0);     chk("R1 reset sr", s_req, 0);
    rst_ni = 1;
  endtask

  task automatic t_latency();
    apply("R1 idle", '0, '0, '0, 0, 1, 1, 1, 0);
    pend = 32'h10; en = 32'h10; act = 0;
    #1 chk("R1 no early change", m_req, 0);
    @(negedge clk);
    chk("R1 after edge", m_req, 1);
  endtask

  task automatic t_summary_mask();
    apply("R2 only active", 32'h0000_0100, '1, '0, 8, 1, 0, 0, 0);
    apply("R2 other bit", 32'h0000_0300, '1, '0, 8, 1, 0, 0, 0);
    apply("R2 enable gate", 32'h0000_0200, 32'h0000_0100, '0, 8, 1, 0, 0, 0);
    apply("R2 top bit active", 32'h8000_0000, '1, '0, 31, 1, 0, 0, 0);
  endtask

  task automatic t_out_of_range();
    apply("R3 idx N", 32'h0000_0001, '1, '0, IW'(N), 1, 0, 0, 0);
    apply("R3 idx max", 32'h8000_0000, '1, '0, '1, 1, 0, 0, 0);
  endtask

  task automatic t_machine();
    apply("R4 undelegated", 32'h0000_0040, '1, 32'hFFFF_FFBF, 0, 1, 1, 1, 0);
  endtask

  task automatic t_sup_deleg();
    apply("R5 forwarded trap", 32'h0000_0004, '1, 32'h0000_0004, 0, 1, 1, 1, 0);
    apply("R5 s_en masked", 32'h0000_0004, '1, 32'h0000_0004, 0, 1, 1, 0, 0);
  endtask

  task automatic t_global_deleg_off();
    apply("R6 s_deleg off", 32'h0000_0004, '1, 32'h0000_0004, 0, 1, 0, 1, 0);
  endtask

  task automatic t_men_off();
    apply("R7 m_en off mach", 32'h0000_0008, '1, '0, 0, 0, 1, 1, 0);
    apply("R7 m_en off sup", 32'h0000_0008, '1, '1, 0, 0, 1, 1, 0);
  endtask

  task automatic t_priority();
    apply("R8 both paths", 32'h0000_0030, '1, 32'h0000_0010, 0, 1, 1, 1, 0);
    apply("R8 inject+mach", 32'h0000_0020, '1, '0, 0, 1, 1, 1, 1);
  endtask

  task automatic t_inject();
    apply("R9 inject alone", '0, '0, '0, 0, 1, 0, 1, 1);
    apply("R9 inject masked", '0, '0, '0, 0, 1, 0, 0, 1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] p, e, d;
      logic [IW-1:0] a;
      logic [3:0] c;
      p = $urandom & $urandom; e = $urandom | $urandom; d = $urandom;
      if (i % 3 == 0) begin p = N'(1) << (i % N); e = '1; end
      a = IW'($urandom_range(0, N + 3));
      c = 4'($urandom);
      apply("R1 R2 R5 R8 random", p, e, d, a, c[0], c[1], c[2], c[3]);
    end
  endtask

  initial begin
    t_reset();
    t_latency();
    t_summary_mask();
    t_out_of_range();
    t_machine();
    t_sup_deleg();
    t_global_deleg_off();
    t_men_off();
    t_priority();
    t_inject();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule